// File: doc/BRIEF.md
# Nonvolatile Store/Recall Arbitration Controller

This controller sits beside a shadow-SRAM array and decides when the array is copied into its nonvolatile cells (a store) and when the nonvolatile image is copied back (a recall). A store can be triggered in two ways. One is an active-low hardware request line, which opens a fixed delay window before anything happens. The other is a one-cycle software store pulse from an external address-sequence decoder, which starts at once. A software recall pulse and a power-good comparator flag trigger recalls. A store runs as an erase phase followed by a program phase. A recall runs as a clear phase followed by a transfer phase. The controller pulses a start strobe at the beginning of each phase.

While the delay window is open, reads go on as normal. A write that was already under way when the request arrived may finish. Every new write is held off until the request line goes high again. A hardware-triggered store happens only if some write has completed since the last store or recall; otherwise the request has no effect. While any phase runs, and while power is low, the SRAM port is disabled. The active-low busy output is driven low for the whole of every store. When power drops, a recall is latched. When power returns, that recall runs with its own, longer transfer time. Reset leaves the block in the power-low state, so the first rise of power-good always performs a recall.

Top module: `nv_cycle_ctrl`

## Requirements
- R1: After reset, `port_dis_o`=1, `wr_inhibit_o`=1 and `busy_no`=1. The first cycle with `pwr_ok_i`=1 starts a recall: CLR_CYC clear cycles, then HW_XFER_CYC transfer cycles, with one `clear_start_o` pulse and one `xfer_start_o` pulse.
- R2: A low level on `hw_req_ni`, sampled while idle and re-armed, opens a delay window of DLY_CYC cycles. The erase phase, if any, begins on the cycle after the window ends.
- R3: A hardware-requested store takes place only if the dirty flag is set when the window ends. Otherwise no store, no strobe and no busy cycle follow.
- R4: A write that is high in the same cycle the request is first sampled, and that stays high without a gap, sees `wr_inhibit_o`=0 and is counted as a completed write.
- R5: Any write that begins after the request has been sampled sees `wr_inhibit_o`=1 as long as `hw_req_ni`=0, and it does not set the dirty flag.
- R6: `busy_no` is 0 for exactly ERASE_CYC+PROG_CYC cycles per store, whether hardware or software triggered it. It is 1 during recalls and during idle time.
- R7: `port_dis_o` is 1 in every store phase, every recall phase and while power is low. `wr_inhibit_o` is 1 whenever `port_dis_o` is 1.
- R8: A store pulses `erase_start_o` and then `prog_start_o`. A recall pulses `clear_start_o` and then `xfer_start_o`. Each strobe lasts one cycle, and at most one strobe is high at a time.
- R9: `pwr_ok_i`=0 forces the power-low state on the next cycle from any state. On return, a recall of CLR_CYC+HW_XFER_CYC cycles runs.
- R10: A write accepted at the port sets the dirty flag. The end of every store or recall clears it.
- R11: Software pulses that arrive when the controller is not idle are ignored. A hardware request made during a software store is merged into that store, and no second store follows.
- R12: A software store runs without regard to the dirty flag. A software recall lasts CLR_CYC+XFER_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_ni | input | 1 | Hardware store request, active low, synchronous |
| sw_store_i | input | 1 | One-cycle software store command |
| sw_recall_i | input | 1 | One-cycle software recall command |
| pwr_ok_i | input | 1 | Supply above switch threshold |
| wr_i | input | 1 | SRAM write strobe for this cycle |
| busy_no | output | 1 | Low during a store (open-drain enable) |
| wr_inhibit_o | output | 1 | Block SRAM writes this cycle |
| port_dis_o | output | 1 | Disable SRAM port inputs and outputs |
| erase_start_o | output | 1 | Start of erase phase |
| prog_start_o | output | 1 | Start of program phase |
| clear_start_o | output | 1 | Start of SRAM clear phase |
| xfer_start_o | output | 1 | Start of nonvolatile-to-SRAM transfer phase |

## Verification
`wr_inhibit_o` depends combinationally on `hw_req_ni` and `wr_i`, so the bench checks it 1 ns after driving inputs at the falling edge, inside the same cycle. The state-driven outputs and the strobes change one clock edge after the input that causes them. A hardware request therefore shows its first busy cycle DLY_CYC+1 edges after it is sampled. The bench does not sample at single fixed instants. It counts busy, port-disable and strobe cycles at every falling edge across a window long enough to contain the whole phase sequence, and compares those counts with phase lengths taken from the parameters.

// File: rtl/nv_pkg.sv
package nv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DELAY = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROG  = 3'd3,
    ST_CLEAR = 3'd4,
    ST_XFER  = 3'd5,
    ST_PWRLO = 3'd6
  } nv_state_e;
endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/nv_access_guard.sv
module nv_access_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_low_i,
  input  logic req_take_i,
  input  logic in_delay_i,
  input  logic port_dis_i,
  input  logic wr_i,
  input  logic clr_dirty_i,
  output logic wr_inhibit_o,
  output logic dirty_o
);
  logic grace_q, grace_ok, wr_accept;

  // write in flight when the request was sampled may run on without a gap
  assign grace_ok     = wr_i & (req_take_i | (in_delay_i & grace_q));
  assign wr_inhibit_o = port_dis_i | (hw_low_i & ~grace_ok);
  assign wr_accept    = wr_i & ~wr_inhibit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grace_q <= 1'b0;
      dirty_o <= 1'b0;
    end else begin
      if (req_take_i)      grace_q <= wr_i;
      else if (in_delay_i) grace_q <= grace_q & wr_i;
      else                 grace_q <= 1'b0;

      if (clr_dirty_i)    dirty_o <= 1'b0;
      else if (wr_accept) dirty_o <= 1'b1;
    end
  end
endmodule

// File: rtl/nv_cycle_ctrl.sv
module nv_cycle_ctrl
  import nv_pkg::*;
#(
  parameter int unsigned DLY_CYC     = 4,
  parameter int unsigned ERASE_CYC   = 3,
  parameter int unsigned PROG_CYC    = 3,
  parameter int unsigned CLR_CYC     = 2,
  parameter int unsigned XFER_CYC    = 3,
  parameter int unsigned HW_XFER_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_req_ni,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic pwr_ok_i,
  input  logic wr_i,
  output logic busy_no,
  output logic wr_inhibit_o,
  output logic port_dis_o,
  output logic erase_start_o,
  output logic prog_start_o,
  output logic clear_start_o,
  output logic xfer_start_o
);
  localparam int unsigned M0 = (DLY_CYC > ERASE_CYC) ? DLY_CYC : ERASE_CYC;
  localparam int unsigned M1 = (PROG_CYC > CLR_CYC) ? PROG_CYC : CLR_CYC;
  localparam int unsigned M2 = (XFER_CYC > HW_XFER_CYC) ? XFER_CYC : HW_XFER_CYC;
  localparam int unsigned M3 = (M0 > M1) ? M0 : M1;
  localparam int unsigned MAX_CYC = (M3 > M2) ? M3 : M2;
  localparam int unsigned CW = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  nv_state_e state_q, state_d;
  logic hw_low, req_take, seen_q, hw_rcl_q, done, phase_chg, dirty, clr_dirty;
  logic [CW-1:0] load_val;

  assign hw_low   = ~hw_req_ni;
  assign req_take = (state_q == ST_IDLE) & pwr_ok_i & hw_low & ~seen_q;

  always_comb begin
    state_d = state_q;
    if (!pwr_ok_i) state_d = ST_PWRLO;
    else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_take)         state_d = ST_DELAY;
          else if (sw_store_i)  state_d = ST_ERASE;
          else if (sw_recall_i) state_d = ST_CLEAR;
        end
        ST_DELAY: if (done) state_d = dirty ? ST_ERASE : ST_IDLE;
        ST_ERASE: if (done) state_d = ST_PROG;
        ST_PROG:  if (done) state_d = ST_IDLE;
        ST_CLEAR: if (done) state_d = ST_XFER;
        ST_XFER:  if (done) state_d = ST_IDLE;
        ST_PWRLO: state_d = ST_CLEAR;
        default:  state_d = ST_PWRLO;
      endcase
    end
  end

  assign phase_chg = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_DELAY: load_val = CW'(DLY_CYC - 1);
      ST_ERASE: load_val = CW'(ERASE_CYC - 1);
      ST_PROG:  load_val = CW'(PROG_CYC - 1);
      ST_CLEAR: load_val = CW'(CLR_CYC - 1);
      ST_XFER:  load_val = hw_rcl_q ? CW'(HW_XFER_CYC - 1) : CW'(XFER_CYC - 1);
      default:  load_val = '0;
    endcase
  end

  nv_phase_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (phase_chg),
    .load_val_i(load_val),
    .done_o    (done)
  );

  assign clr_dirty = pwr_ok_i & done & ((state_q == ST_PROG) | (state_q == ST_XFER));

  nv_access_guard u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_low_i    (hw_low),
    .req_take_i  (req_take),
    .in_delay_i  (state_q == ST_DELAY),
    .port_dis_i  (port_dis_o),
    .wr_i        (wr_i),
    .clr_dirty_i (clr_dirty),
    .wr_inhibit_o(wr_inhibit_o),
    .dirty_o     (dirty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_PWRLO;
      seen_q        <= 1'b0;
      hw_rcl_q      <= 1'b1;
      erase_start_o <= 1'b0;
      prog_start_o  <= 1'b0;
      clear_start_o <= 1'b0;
      xfer_start_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      // request re-arms only after the line returns high; merges into a running store
      if (hw_req_ni) seen_q <= 1'b0;
      else if (req_take || state_q == ST_ERASE || state_q == ST_PROG) seen_q <= 1'b1;
      if (state_q == ST_PWRLO && state_d == ST_CLEAR)     hw_rcl_q <= 1'b1;
      else if (state_q == ST_IDLE && state_d == ST_CLEAR) hw_rcl_q <= 1'b0;
      erase_start_o <= phase_chg & (state_d == ST_ERASE);
      prog_start_o  <= phase_chg & (state_d == ST_PROG);
      clear_start_o <= phase_chg & (state_d == ST_CLEAR);
      xfer_start_o  <= phase_chg & (state_d == ST_XFER);
    end
  end

  assign busy_no    = ~((state_q == ST_ERASE) | (state_q == ST_PROG));
  assign port_dis_o = (state_q != ST_IDLE) & (state_q != ST_DELAY);
endmodule

// File: rtl/nv_cycle_ctrl_chk.sv
module nv_cycle_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hw_req_ni,
  input logic pwr_ok_i,
  input logic wr_i,
  input logic busy_no,
  input logic wr_inhibit_o,
  input logic port_dis_o,
  input logic erase_start_o,
  input logic prog_start_o,
  input logic clear_start_o,
  input logic xfer_start_o
);
  p_dis_inhibit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_dis_o |-> wr_inhibit_o);
  p_busy_dis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> port_dis_o);
  p_strobe_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_start_o, prog_start_o, clear_start_o, xfer_start_o}));
  p_erase_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> !busy_no);
  p_prog_after_erase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(!busy_no));
  p_pwr_dis_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> port_dis_o);
  p_req_inhibit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_req_ni && !wr_i) |-> wr_inhibit_o);
  p_recall_not_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_start_o || xfer_start_o) |-> busy_no);
endmodule

bind nv_cycle_ctrl nv_cycle_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hw_req_ni    (hw_req_ni),
  .pwr_ok_i     (pwr_ok_i),
  .wr_i         (wr_i),
  .busy_no      (busy_no),
  .wr_inhibit_o (wr_inhibit_o),
  .port_dis_o   (port_dis_o),
  .erase_start_o(erase_start_o),
  .prog_start_o (prog_start_o),
  .clear_start_o(clear_start_o),
  .xfer_start_o (xfer_start_o)
);

// File: tb/nv_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module nv_cycle_ctrl_tb_top;
  localparam int DLY = 4, ER = 3, PG = 3, CL = 2, XF = 3, HXF = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hw_req_ni = 1'b1, sw_store_i = 1'b0, sw_recall_i = 1'b0, pwr_ok_i = 1'b0, wr_i = 1'b0;
  logic busy_no, wr_inhibit_o, port_dis_o, erase_start_o, prog_start_o, clear_start_o, xfer_start_o;

  int n_chk = 0, n_bad = 0;
  int c_busy, c_dis, c_er, c_pg, c_cl, c_xf;
  bit fin = 0;

  always #10 clk_i = ~clk_i;

  nv_cycle_ctrl #(.DLY_CYC(DLY), .ERASE_CYC(ER), .PROG_CYC(PG),
                  .CLR_CYC(CL), .XFER_CYC(XF), .HW_XFER_CYC(HXF)) dut_i (
    .clk_i, .rst_ni, .hw_req_ni, .sw_store_i, .sw_recall_i, .pwr_ok_i, .wr_i,
    .busy_no, .wr_inhibit_o, .port_dis_o, .erase_start_o, .prog_start_o,
    .clear_start_o, .xfer_start_o);

  // {write before request, write in flight at request, late write, store expected}
  localparam logic [3:0] VEC [0:5] = '{4'b0000, 4'b1001, 4'b0101, 4'b0010, 4'b0000, 4'b1011};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic window(input int n);
    c_busy = 0; c_dis = 0; c_er = 0; c_pg = 0; c_cl = 0; c_xf = 0;
    repeat (n) begin
      @(posedge clk_i); @(negedge clk_i);
      c_busy += int'(!busy_no); c_dis += int'(port_dis_o);
      c_er += int'(erase_start_o); c_pg += int'(prog_start_o);
      c_cl += int'(clear_start_o); c_xf += int'(xfer_start_o);
    end
  endtask

  task automatic do_write();
    @(negedge clk_i); wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic hw_probe(input string req, input int exp_busy);
    @(negedge clk_i); hw_req_ni = 1'b0;
    window(20);
    chk(req, c_busy, exp_busy);
    hw_req_ni = 1'b1;
    window(3);
  endtask

  initial begin
    #(20 * 5000);
    if (!fin) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset port_dis", int'(port_dis_o), 1);
    chk("R1 reset busy_no", int'(busy_no), 1);
    chk("R1 reset inhibit", int'(wr_inhibit_o), 1);
    pwr_ok_i = 1'b1;
    window(20);
    chk("R1 powerup recall dis cycles", c_dis, CL + HXF);
    chk("R1 powerup clear strobe", c_cl, 1);
    chk("R8 powerup xfer strobe", c_xf, 1);
    chk("R6 recall not busy", c_busy, 0);

    foreach (VEC[i]) begin
      automatic logic [3:0] v = VEC[i];
      if (v[3]) do_write();
      @(negedge clk_i); hw_req_ni = 1'b0; wr_i = v[2];
      #1;
      chk(v[2] ? "R4 grace at request" : "R5 inhibit at request", int'(wr_inhibit_o), v[2] ? 0 : 1);
      @(negedge clk_i);
      if (v[2]) begin
        #1 chk("R4 grace in window", int'(wr_inhibit_o), 0);
        wr_i = 1'b0;
      end
      if (v[1]) begin
        @(negedge clk_i); wr_i = 1'b1;
        #1 chk("R5 late write inhibited", int'(wr_inhibit_o), 1);
        @(negedge clk_i); wr_i = 1'b0;
      end
      window(20);
      chk("R3 R6 hw store busy cycles", c_busy, v[0] ? ER + PG : 0);
      chk("R8 erase strobe", c_er, v[0] ? 1 : 0);
      chk("R8 prog strobe", c_pg, v[0] ? 1 : 0);
      hw_req_ni = 1'b1;
      window(3);
    end

    // R2: busy starts DLY+1 edges after the request edge
    do_write();
    @(negedge clk_i); hw_req_ni = 1'b0;
    window(DLY);
    chk("R2 no busy inside window", c_busy, 0);
    window(1);
    chk("R2 erase after window", c_er, 1);
    window(12);
    hw_req_ni = 1'b1;
    window(3);

    // R12: software store when clean, recall pulse ignored mid-store (R11)
    @(negedge clk_i); sw_store_i = 1'b1;
    @(negedge clk_i); sw_store_i = 1'b0;
    chk("R12 sw store erase strobe", int'(erase_start_o), 1);
    @(negedge clk_i); sw_recall_i = 1'b1;
    @(negedge clk_i); sw_recall_i = 1'b0;
    window(15);
    chk("R11 sw recall ignored", c_cl, 0);

    // R11 merge: hw request during sw store
    @(negedge clk_i); sw_store_i = 1'b1;
    @(negedge clk_i); sw_store_i = 1'b0;
    hw_req_ni = 1'b0; c_busy = 1;
    begin
      int b = 1;
      window(20); b += c_busy;
      chk("R11 merged store busy cycles", b, ER + PG);
    end
    #1 chk("R5 inhibit while line low after store", int'(wr_inhibit_o), 1);
    hw_req_ni = 1'b1;
    window(3);

    // R12 sw recall length, R10 dirty cleared by it
    do_write();
    @(negedge clk_i); sw_recall_i = 1'b1;
    @(negedge clk_i); sw_recall_i = 1'b0;
    chk("R12 sw recall clear strobe", int'(clear_start_o), 1);
    begin
      int d = 1;
      window(15); d += c_dis;
      chk("R12 sw recall dis cycles", d, CL + XF);
    end
    hw_probe("R10 clean after sw recall", 0);

    // R9 power cycle with dirty array
    do_write();
    @(negedge clk_i); pwr_ok_i = 1'b0;
    window(1);
    chk("R9 power low disables port", int'(port_dis_o), 1);
    chk("R7 inhibit while power low", int'(wr_inhibit_o), 1);
    window(3);
    pwr_ok_i = 1'b1;
    window(20);
    chk("R9 power recall dis cycles", c_dis, CL + HXF);
    chk("R9 power recall xfer strobe", c_xf, 1);
    hw_probe("R10 clean after power recall", 0);

    // R7 write inhibited during store, and R10 write before store cleared
    do_write();
    @(negedge clk_i); sw_store_i = 1'b1;
    @(negedge clk_i); sw_store_i = 1'b0; wr_i = 1'b1;
    #1 chk("R7 inhibit during store", int'(wr_inhibit_o), 1);
    @(negedge clk_i); wr_i = 1'b0;
    window(12);
    hw_probe("R10 clean after store", 0);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule